// File: doc/BRIEF.md
# Counter-Compare Watchdog Timer

This block watches for a stalled CPU. A free-running 16-bit counter advances on a prescaled counter clock. The low byte sets the fine step and the high byte sets the coarse one. A match byte holds a deadline. Each time the low byte rolls over, the high byte is compared with that match byte. If they are equal while the watchdog is armed, a one-cycle reset pulse goes out.

Software services the watchdog by kicking it. A kick loads the match byte with the current high byte plus a programmed offset byte, so the deadline moves forward by a chosen number of low-byte rollovers. A configuration write sets the enable, a sticky lock, the counter clock divider and an option to suspend counting while the CPU idles. Software can also fire the reset on purpose. The reset pulse returns every watchdog register to its default. The watchdog therefore comes back armed with its shortest timeout.

Top module: `wdog_core`

## Requirements
- R1: While `rst_n` is low and after its release, `wdt_rst` is low. Out of reset the watchdog is armed and counts at system clock divided by 12. With no writes, `wdt_rst` first goes high on the 3072nd rising clock edge after reset release.
- R2: `wdt_rst` is high for exactly one system clock. That pulse restores every register to its default: configuration, lock, offset, match byte, counter and prescaler. An unserviced watchdog therefore pulses again 3072 clocks after a pulse ends.
- R3: `cfg_sel` picks the counter clock. Code 0 selects system clock divided by 12, code 1 selects divided by 4 and code 2 selects undivided. Every other code selects divided by 12.
- R4: The 16-bit counter advances by one on each counter clock. `wdt_rst` rises one system clock after a counter clock on which the low byte is 255, the high byte equals the match byte and the watchdog is armed.
- R5: A `kick_wr` pulse loads the match byte with the current high byte plus the offset byte. The timeout then lasts 256 × offset + (256 − low byte at the kick) counter clocks.
- R6: The match byte wraps modulo 256. A kick with high byte 1 and offset 255 gives a match of 0, which is reached only after the 16-bit counter wraps.
- R7: The watchdog is armed when the enable bit or the lock bit is set. The lock bit stays set until a reset. With the lock bit clear, a write with `cfg_en` = 0 disarms the watchdog, and no pulse follows.
- R8: While the watchdog is armed, a configuration write leaves the clock select and the idle-suspend setting unchanged. Its enable and lock fields still take effect.
- R9: With idle-suspend set, the counter and the prescaler hold while `cpu_idle` is high. With idle-suspend clear, `cpu_idle` has no effect.
- R10: A `force_wr` pulse while the watchdog is armed raises `wdt_rst` on the next clock edge. While the watchdog is disarmed, it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable bit of a configuration write |
| cfg_lock | input | 1 | Lock bit of a configuration write (setting only) |
| cfg_sel | input | 3 | Counter clock select code |
| cfg_idle_stop | input | 1 | Suspend counting while the CPU idles |
| ofs_wr | input | 1 | Offset byte write strobe |
| ofs_data | input | 8 | Offset byte value |
| kick_wr | input | 1 | Service strobe that reloads the match byte |
| force_wr | input | 1 | Request an immediate watchdog reset |
| cpu_idle | input | 1 | CPU idle indication |
| wdt_rst | output | 1 | One-clock watchdog reset pulse |

## Verification
The hardest case to reach is a match byte that wraps past 255. The deadline then lies beyond a full 16-bit roll of the counter. An early pulse at the unwrapped deadline would look much like a correct run. The bench switches to the undivided clock, then kicks once with offset 1 to lift the high byte to 1. It then kicks with offset 255 at an exactly known edge. It checks that the first pulse lands on the single edge where the counter comes back around, and not 256 counts earlier. The idle-suspend and divider cases also start from a reset at a known edge. This lets the bench predict every pulse to the exact clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int SEL_W = 3;

    // counter clock select codes
    localparam logic [SEL_W-1:0] SEL_DIV_SLOW = 3'd0;
    localparam logic [SEL_W-1:0] SEL_DIV_FAST = 3'd1;
    localparam logic [SEL_W-1:0] SEL_DIV_NONE = 3'd2;

    typedef struct packed {
        logic             en;
        logic             lock;
        logic [SEL_W-1:0] sel;
        logic             idle_stop;
    } wdog_mode_t;

    localparam wdog_mode_t MODE_DEFAULT = '{en: 1'b1, lock: 1'b0,
                                           sel: SEL_DIV_SLOW, idle_stop: 1'b0};

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale
    import wdog_pkg::*;
#(
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hold,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int PW      = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_st_t;

    pre_st_t       st_d, st_q;
    logic [PW-1:0] lim;
    logic          at_lim;

    always_comb begin
        case (sel)
            SEL_DIV_FAST: lim = PW'(FAST_DIV - 1);
            SEL_DIV_NONE: lim = '0;
            default:      lim = PW'(SLOW_DIV - 1);
        endcase
        at_lim = (st_q.cnt >= lim);
        tick   = !hold && at_lim;
        st_d   = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (!hold) begin
            st_d.cnt = at_lim ? '0 : st_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold && !clr |=> $stable(st_q.cnt));

    // R3
    pre_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && sel != SEL_DIV_NONE && !clr |=> !tick);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int LO_W = 8,
    parameter int HI_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            adv,
    output logic [HI_W-1:0] hi,
    output logic            lo_wrap
);

    localparam int CNT_W = LO_W + HI_W;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (adv) begin
            st_d = cnt_st_t'(st_q + CNT_W'(1));
        end
        hi      = st_q.hi;
        lo_wrap = adv && (&st_q.lo);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv && !clr |=> $stable(st_q));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !clr |=> st_q == cnt_st_t'($past(st_q) + CNT_W'(1)));

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int HI_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_en,
    input  logic             cfg_lock,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             cfg_idle_stop,
    input  logic             ofs_wr,
    input  logic [HI_W-1:0]  ofs_data,
    input  logic             kick_wr,
    input  logic             force_wr,
    input  logic             lo_wrap,
    input  logic [HI_W-1:0]  hi,
    output logic [SEL_W-1:0] sel,
    output logic             idle_stop,
    output logic             pulse
);

    typedef struct packed {
        wdog_mode_t      mode;
        logic [HI_W-1:0] ofs;
        logic [HI_W-1:0] match;
        logic            pulse;
    } ctl_st_t;

    localparam ctl_st_t CTL_DEFAULT = '{mode: MODE_DEFAULT, ofs: '0,
                                        match: '0, pulse: 1'b0};

    ctl_st_t st_d, st_q;
    logic    armed;
    logic    deadline;

    always_comb begin
        armed    = st_q.mode.en || st_q.mode.lock;
        deadline = lo_wrap && (hi == st_q.match);
        st_d       = st_q;
        st_d.pulse = armed && (deadline || force_wr);
        if (cfg_wr) begin
            st_d.mode.en   = cfg_en;
            st_d.mode.lock = st_q.mode.lock || cfg_lock;
            if (!armed) begin
                st_d.mode.sel       = cfg_sel;
                st_d.mode.idle_stop = cfg_idle_stop;
            end
        end
        if (ofs_wr)  st_d.ofs   = ofs_data;
        if (kick_wr) st_d.match = hi + st_q.ofs;
        if (st_q.pulse) st_d = CTL_DEFAULT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTL_DEFAULT;
        else        st_q <= st_d;
    end

    assign sel       = st_q.mode.sel;
    assign idle_stop = st_q.mode.idle_stop;
    assign pulse     = st_q.pulse;

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode.lock && !st_q.pulse |=> st_q.mode.lock);

    // R10
    pulse_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> $past(st_q.mode.en || st_q.mode.lock));

    // R8
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !st_q.pulse |=> $stable(st_q.mode.sel) && $stable(st_q.mode.idle_stop));

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int LO_W     = 8,
    parameter int HI_W     = 8,
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_en,
    input  logic             cfg_lock,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             cfg_idle_stop,
    input  logic             ofs_wr,
    input  logic [HI_W-1:0]  ofs_data,
    input  logic             kick_wr,
    input  logic             force_wr,
    input  logic             cpu_idle,
    output logic             wdt_rst
);

    logic             tick;
    logic             lo_wrap;
    logic [HI_W-1:0]  hi;
    logic [SEL_W-1:0] sel;
    logic             idle_stop;
    logic             pulse;
    logic             hold;

    assign hold    = idle_stop && cpu_idle;
    assign wdt_rst = pulse;

    wdog_prescale #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) pre_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pulse),
        .hold  (hold),
        .sel   (sel),
        .tick  (tick)
    );

    wdog_counter #(.LO_W(LO_W), .HI_W(HI_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pulse),
        .adv     (tick),
        .hi      (hi),
        .lo_wrap (lo_wrap)
    );

    wdog_ctrl #(.HI_W(HI_W)) ctl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr        (cfg_wr),
        .cfg_en        (cfg_en),
        .cfg_lock      (cfg_lock),
        .cfg_sel       (cfg_sel),
        .cfg_idle_stop (cfg_idle_stop),
        .ofs_wr        (ofs_wr),
        .ofs_data      (ofs_data),
        .kick_wr       (kick_wr),
        .force_wr      (force_wr),
        .lo_wrap       (lo_wrap),
        .hi            (hi),
        .sel           (sel),
        .idle_stop     (idle_stop),
        .pulse         (pulse)
    );

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);

endmodule

// File: tb/wdog_core_tb_top.sv
module wdog_core_tb_top;

    localparam int CLK_T = 10;
    localparam int NVEC  = 5;
    localparam int VEC_SEL [NVEC] = '{0, 1, 2, 5, 7};
    localparam int VEC_EXP [NVEC] = '{3072, 1024, 258, 3072, 3072};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0, cfg_en = 1'b0, cfg_lock = 1'b0, cfg_idle_stop = 1'b0;
    logic [2:0] cfg_sel = 3'd0;
    logic       ofs_wr = 1'b0;
    logic [7:0] ofs_data = 8'd0;
    logic       kick_wr = 1'b0, force_wr = 1'b0, cpu_idle = 1'b0;
    logic       wdt_rst;

    int cyc = 0;
    int total = 0;
    int bad = 0;

    always #(CLK_T/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    wdog_core dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .cfg_lock(cfg_lock), .cfg_sel(cfg_sel), .cfg_idle_stop(cfg_idle_stop),
        .ofs_wr(ofs_wr), .ofs_data(ofs_data), .kick_wr(kick_wr),
        .force_wr(force_wr), .cpu_idle(cpu_idle), .wdt_rst(wdt_rst)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic por();
        rst_n = 1'b0; cfg_wr = 0; kick_wr = 0; force_wr = 0; ofs_wr = 0; cpu_idle = 0;
        repeat (3) @(negedge clk);
        chk("R1 low in reset", int'(wdt_rst), 0);
        rst_n = 1'b1;
    endtask

    task automatic at_edge(input int e);
        while (cyc < e - 1) @(negedge clk);
    endtask

    task automatic cfg_write(input logic en, input logic lk, input logic [2:0] s, input logic idl);
        cfg_wr = 1; cfg_en = en; cfg_lock = lk; cfg_sel = s; cfg_idle_stop = idl;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic ofs_write(input logic [7:0] v);
        ofs_wr = 1; ofs_data = v;
        @(negedge clk);
        ofs_wr = 0;
    endtask

    task automatic kick();
        kick_wr = 1;
        @(negedge clk);
        kick_wr = 0;
    endtask

    task automatic force_rst();
        force_wr = 1;
        @(negedge clk);
        force_wr = 0;
    endtask

    task automatic wait_pulse(input int lim, output int at);
        while (!wdt_rst && cyc < lim) @(negedge clk);
        at = wdt_rst ? cyc : -1;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_T * 190000);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        int at;
        @(negedge clk);

        // R3 clock select vectors
        for (int i = 0; i < NVEC; i++) begin
            por();
            at_edge(1); cfg_write(0, 0, 3'd0, 0);
            at_edge(2); cfg_write(0, 0, 3'(VEC_SEL[i]), 0);
            at_edge(3); cfg_write(1, 0, 3'(VEC_SEL[i]), 0);
            wait_pulse(VEC_EXP[i] + 20, at);
            chk($sformatf("R3 sel=%0d pulse edge", VEC_SEL[i]), at, VEC_EXP[i]);
        end

        // R1 default timeout, R2 width and repeat
        por();
        chk("R1 low after release", int'(wdt_rst), 0);
        wait_pulse(4000, at);
        chk("R1 default pulse edge", at, 3072);
        @(negedge clk);
        chk("R2 pulse one clock wide", int'(wdt_rst), 0);
        wait_pulse(7000, at);
        chk("R2 repeat after self reset", at, 6145);

        // R5 kick with offset 1
        por();
        at_edge(5); ofs_write(8'd1);
        at_edge(30); kick();
        wait_pulse(7000, at);
        chk("R5 offset 1 timeout", at, 6144);

        // R5 second kick moves deadline again (R4 compare on high byte)
        por();
        at_edge(5); ofs_write(8'd1);
        at_edge(30); kick();
        at_edge(5000); kick();
        wait_pulse(10000, at);
        chk("R4 R5 rekick deadline", at, 9216);

        // R6 match wraps modulo 256
        por();
        at_edge(1); cfg_write(0, 0, 3'd0, 0);
        at_edge(2); cfg_write(0, 0, 3'd2, 0);
        at_edge(3); cfg_write(1, 0, 3'd2, 0);
        at_edge(4); ofs_write(8'd1);
        at_edge(5); kick();
        at_edge(300); ofs_write(8'd255);
        at_edge(301); kick();
        wait_pulse(70000, at);
        chk("R6 wrapped match pulse edge", at, 65794);

        // R7 lock sticky, R8 select ignored while armed
        por();
        at_edge(1); cfg_write(0, 1, 3'd0, 0);
        at_edge(2); cfg_write(0, 0, 3'd2, 0);
        wait_pulse(4000, at);
        chk("R7 R8 locked keeps running at div12", at, 3072);
        at_edge(3080); cfg_write(0, 0, 3'd0, 0);
        wait_pulse(6400, at);
        chk("R7 lock cleared by pulse then disarmed", at, -1);

        // R8 select ignored while armed by enable
        por();
        at_edge(1); cfg_write(1, 0, 3'd2, 0);
        wait_pulse(4000, at);
        chk("R8 select write ignored", at, 3072);

        // R8 idle-suspend ignored while armed; R9 idle has no effect without suspend
        por();
        at_edge(1); cfg_write(1, 0, 3'd0, 1);
        cpu_idle = 1;
        wait_pulse(4000, at);
        cpu_idle = 0;
        chk("R8 R9 idle ignored", at, 3072);

        // R9 idle suspend holds counting
        por();
        at_edge(1); cfg_write(0, 0, 3'd0, 0);
        at_edge(2); cfg_write(0, 0, 3'd2, 1);
        at_edge(3); cfg_write(1, 0, 3'd2, 1);
        at_edge(10); cpu_idle = 1;
        at_edge(1010); cpu_idle = 0;
        wait_pulse(2000, at);
        chk("R9 suspended pulse edge", at, 1258);

        // R10 forced reset while armed
        por();
        at_edge(100); force_rst();
        wait_pulse(200, at);
        chk("R10 forced pulse edge", at, 100);

        // R10 force ignored and R7 disarm when unlocked
        por();
        at_edge(1); cfg_write(0, 0, 3'd0, 0);
        at_edge(50); force_rst();
        wait_pulse(4000, at);
        chk("R7 R10 disarmed no pulse", at, -1);

        finish_run();
    end

endmodule